// File: doc/BRIEF.md
# Reset-Time Strap Pattern Driver

This block takes over a 16-bit processor data bus while the system reset line is held and drives a fixed strap word onto it. The host processor latches its start-up options from the data bus when reset is released. Normally a pair of external buffers would drive that word. Here the same pins that serve as the normal data port supply it, and the block then returns those pins to ordinary data-port control.

The raw system reset passes through a two-stage synchroniser before it can enable the strap drive. Strap drive also needs the mode-enable bit to be set. It gives way at once whenever a bus transfer is flagged as active. The 16-bit word is split across two 8-bit port halves: the upper byte goes to the high half and the lower byte to the low half. The word is a static input; loading it into nonvolatile storage happens elsewhere.

Top module: `rst_strap_drv`

## Requirements
- R1: When strap drive is in effect, every pin output enable is 1 and the pins carry `strap_word`.
- R2: `strap_word[15:8]` appears on `pin_hi` and `strap_word[7:0]` appears on `pin_lo`. Bit i of each half maps to bit i of its byte.
- R3: While `bus_busy` is 1, the pins and enables equal `port_dout` and `port_oe` in that same cycle. No clock edge is needed for the hand-back.
- R4: While `mode_en` is 0, `sys_rst_raw` has no effect, and the pins and enables always equal the data-port signals.
- R5: Strap drive begins only after `sys_rst_raw` has been sampled high on two consecutive rising edges. It becomes visible after the third edge, counted from the first edge that sees the line high.
- R6: The strap word stays on the pins through the first rising edge after `sys_rst_raw` falls. The pins return to data-port control on the second edge, which is the edge where the synchronised reset falls.
- R7: A synchronous `rst` clears the synchroniser and the drive window, so that the pins follow the data port.
- R8: Outside strap drive, `{pin_hi,pin_lo}` equals `port_dout` and `{pin_oe_hi,pin_oe_lo}` equals `port_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high block reset |
| sys_rst_raw | input | 1 | Asynchronous system reset line, active high |
| bus_busy | input | 1 | A bus transfer is in progress |
| mode_en | input | 1 | Enables strap drive during reset |
| strap_word | input | 16 | Static strap pattern |
| port_dout | input | 16 | Normal data-port output value |
| port_oe | input | 16 | Normal data-port per-pin output enable |
| pin_hi | output | 8 | Upper-half pin value |
| pin_oe_hi | output | 8 | Upper-half pin output enables |
| pin_lo | output | 8 | Lower-half pin value |
| pin_oe_lo | output | 8 | Lower-half pin output enables |

## Verification
The pins are a combinational function of the current `bus_busy`, `mode_en`, strap word and port inputs, together with the two most recent synchronised samples of the reset line. A change to `bus_busy` or `mode_en` therefore shows in the same cycle. A change to the raw reset line starts strap drive after three rising edges and ends it after two. The bench records the raw line at every rising edge and derives the expected pin state from the samples taken one and two edges back. Inputs change on the falling edge and the outputs are sampled shortly after it, so each check sees a settled result.

// File: rtl/rsd_pkg.sv
package rsd_pkg;
  localparam int unsigned RSD_HALF_W_DEF      = 8;
  localparam int unsigned RSD_SYNC_STAGES_DEF = 2;
  localparam int unsigned RSD_HALVES          = 2;
endpackage

// File: rtl/rsd_sync.sv
module rsd_sync #(
  parameter int unsigned STAGES = rsd_pkg::RSD_SYNC_STAGES_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rsd_window.sv
module rsd_window (
  input  logic clk,
  input  logic rst,
  input  logic rst_sync,
  input  logic mode_en,
  input  logic bus_busy,
  output logic take
);
  logic win_q;
  logic release_edge;

  always_ff @(posedge clk) begin
    if (rst) win_q <= 1'b0;
    else     win_q <= rst_sync;
  end

  // falling edge of the synchronised reset ends the window on that same edge
  assign release_edge = win_q & ~rst_sync;
  assign take = mode_en & win_q & ~release_edge & ~bus_busy;
endmodule

// File: rtl/rsd_half_mux.sv
module rsd_half_mux #(
  parameter int unsigned W = rsd_pkg::RSD_HALF_W_DEF
) (
  input  logic         take,
  input  logic [W-1:0] strap,
  input  logic [W-1:0] dout,
  input  logic [W-1:0] oe_in,
  output logic [W-1:0] pin,
  output logic [W-1:0] pin_oe
);
  generate
    genvar b;
    for (b = 0; b < W; b++) begin : g_bit
      always_comb begin
        pin[b]    = take ? strap[b] : dout[b];
        pin_oe[b] = take ? 1'b1     : oe_in[b];
      end
    end
  endgenerate
endmodule

// File: rtl/rst_strap_drv.sv
module rst_strap_drv #(
  parameter int unsigned HALF_W      = rsd_pkg::RSD_HALF_W_DEF,
  parameter int unsigned SYNC_STAGES = rsd_pkg::RSD_SYNC_STAGES_DEF
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sys_rst_raw,
  input  logic                  bus_busy,
  input  logic                  mode_en,
  input  logic [2*HALF_W-1:0]   strap_word,
  input  logic [2*HALF_W-1:0]   port_dout,
  input  logic [2*HALF_W-1:0]   port_oe,
  output logic [HALF_W-1:0]     pin_hi,
  output logic [HALF_W-1:0]     pin_oe_hi,
  output logic [HALF_W-1:0]     pin_lo,
  output logic [HALF_W-1:0]     pin_oe_lo
);
  localparam int unsigned NH     = rsd_pkg::RSD_HALVES;
  localparam int unsigned DATA_W = NH * HALF_W;

  logic              rst_sync;
  logic              take;
  logic [DATA_W-1:0] pin_all;
  logic [DATA_W-1:0] oe_all;

  rsd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (sys_rst_raw),
    .q   (rst_sync)
  );

  rsd_window u_win (
    .clk      (clk),
    .rst      (rst),
    .rst_sync (rst_sync),
    .mode_en  (mode_en),
    .bus_busy (bus_busy),
    .take     (take)
  );

  generate
    genvar h;
    for (h = 0; h < NH; h++) begin : g_half
      rsd_half_mux #(.W(HALF_W)) u_mux (
        .take   (take),
        .strap  (strap_word[h*HALF_W +: HALF_W]),
        .dout   (port_dout[h*HALF_W +: HALF_W]),
        .oe_in  (port_oe[h*HALF_W +: HALF_W]),
        .pin    (pin_all[h*HALF_W +: HALF_W]),
        .pin_oe (oe_all[h*HALF_W +: HALF_W])
      );
    end
  endgenerate

  assign pin_lo    = pin_all[HALF_W-1:0];
  assign pin_oe_lo = oe_all[HALF_W-1:0];
  assign pin_hi    = pin_all[DATA_W-1:HALF_W];
  assign pin_oe_hi = oe_all[DATA_W-1:HALF_W];
endmodule

// File: rtl/rst_strap_drv_chk.sv
module rst_strap_drv_chk #(
  parameter int unsigned HALF_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                sys_rst_raw,
  input logic                bus_busy,
  input logic                mode_en,
  input logic [2*HALF_W-1:0] strap_word,
  input logic [2*HALF_W-1:0] port_dout,
  input logic [2*HALF_W-1:0] port_oe,
  input logic [HALF_W-1:0]   pin_hi,
  input logic [HALF_W-1:0]   pin_oe_hi,
  input logic [HALF_W-1:0]   pin_lo,
  input logic [HALF_W-1:0]   pin_oe_lo
);
  logic [1:0] cyc;
  logic       hist_ok;

  always_ff @(posedge clk) begin
    if (rst)               cyc <= 2'd0;
    else if (cyc != 2'd3)  cyc <= cyc + 2'd1;
  end
  assign hist_ok = (cyc == 2'd3);

  p_strap_on_r1: assert property (@(posedge clk) disable iff (rst)
    (hist_ok && mode_en && !bus_busy && $past(sys_rst_raw, 2) && $past(sys_rst_raw, 3))
    |-> ({pin_oe_hi, pin_oe_lo} == '1 && {pin_hi, pin_lo} == strap_word));

  p_busy_handback_r3: assert property (@(posedge clk) disable iff (rst)
    bus_busy |-> ({pin_hi, pin_lo} == port_dout && {pin_oe_hi, pin_oe_lo} == port_oe));

  p_mode_off_r4: assert property (@(posedge clk) disable iff (rst)
    !mode_en |-> ({pin_hi, pin_lo} == port_dout && {pin_oe_hi, pin_oe_lo} == port_oe));

  p_late_start_r5: assert property (@(posedge clk) disable iff (rst)
    (hist_ok && !$past(sys_rst_raw, 3))
    |-> ({pin_hi, pin_lo} == port_dout && {pin_oe_hi, pin_oe_lo} == port_oe));

  p_release_r6: assert property (@(posedge clk) disable iff (rst)
    (hist_ok && !$past(sys_rst_raw, 2))
    |-> ({pin_hi, pin_lo} == port_dout && {pin_oe_hi, pin_oe_lo} == port_oe));
endmodule

bind rst_strap_drv rst_strap_drv_chk #(.HALF_W(HALF_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sys_rst_raw (sys_rst_raw),
  .bus_busy    (bus_busy),
  .mode_en     (mode_en),
  .strap_word  (strap_word),
  .port_dout   (port_dout),
  .port_oe     (port_oe),
  .pin_hi      (pin_hi),
  .pin_oe_hi   (pin_oe_hi),
  .pin_lo      (pin_lo),
  .pin_oe_lo   (pin_oe_lo)
);

// File: tb/rst_strap_drv_bench.sv
module rst_strap_drv_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        sys_rst_raw;
  logic        bus_busy;
  logic        mode_en;
  logic [15:0] strap_word;
  logic [15:0] port_dout;
  logic [15:0] port_oe;
  logic [7:0]  pin_hi, pin_oe_hi, pin_lo, pin_oe_lo;

  int unsigned tests = 0;
  int unsigned fails = 0;
  int unsigned cycles = 0;
  logic [2:0]  hist;   // hist[0] = raw reset at newest edge

  always #10 clk = ~clk;

  rst_strap_drv u_rst_strap_drv (
    .clk(clk), .rst(rst), .sys_rst_raw(sys_rst_raw), .bus_busy(bus_busy),
    .mode_en(mode_en), .strap_word(strap_word), .port_dout(port_dout),
    .port_oe(port_oe), .pin_hi(pin_hi), .pin_oe_hi(pin_oe_hi),
    .pin_lo(pin_lo), .pin_oe_lo(pin_oe_lo)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) hist <= 3'b000;
    else     hist <= {hist[1:0], sys_rst_raw};
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic logic exp_take();
    return mode_en & hist[1] & hist[2] & ~bus_busy;
  endfunction

  function automatic logic [31:0] exp_pins();
    if (exp_take()) return {strap_word, 16'hFFFF};
    return {port_dout, port_oe};
  endfunction

  task automatic check(input string req);
    logic [31:0] act, exp;
    act = {pin_hi, pin_lo, pin_oe_hi, pin_oe_lo};
    exp = exp_pins();
    tests = tests + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_val(input string req, input logic [31:0] exp);
    logic [31:0] act;
    act = {pin_hi, pin_lo, pin_oe_hi, pin_oe_lo};
    tests = tests + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #2;
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; sys_rst_raw = 1'b0; bus_busy = 1'b0; mode_en = 1'b1;
    strap_word = 16'hA55A; port_dout = 16'h1234; port_oe = 16'h00F0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R7 reset state: pins follow data port
    check_val("R7", {16'h1234, 16'h00F0});

    // R5 latency: raw high, drive visible only after the third edge
    @(negedge clk); sys_rst_raw = 1'b1; #2;
    tick(); check_val("R5", {16'h1234, 16'h00F0});
    tick(); check_val("R5", {16'h1234, 16'h00F0});
    tick(); check_val("R1", {16'hA55A, 16'hFFFF});
    // R2 byte split, distinct bytes
    @(negedge clk); strap_word = 16'hC30F; #2;
    tests = tests + 1;
    if (pin_hi !== 8'hC3 || pin_lo !== 8'h0F) begin
      fails = fails + 1;
      $display("FAIL R2: actual=%h%h expected=c30f", pin_hi, pin_lo);
    end
    // R3 busy drops enables in the same cycle
    @(negedge clk); bus_busy = 1'b1; #2;
    check_val("R3", {16'h1234, 16'h00F0});
    @(negedge clk); bus_busy = 1'b0; #2;
    check_val("R1", {16'hC30F, 16'hFFFF});
    // R4 mode off
    @(negedge clk); mode_en = 1'b0; #2;
    check_val("R4", {16'h1234, 16'h00F0});
    @(negedge clk); mode_en = 1'b1; #2;
    // R6 hold through first edge after release, hand back on second
    @(negedge clk); sys_rst_raw = 1'b0; #2;
    check_val("R6", {16'hC30F, 16'hFFFF});
    tick(); check_val("R6", {16'hC30F, 16'hFFFF});
    tick(); check_val("R6", {16'h1234, 16'h00F0});
    tick(); check_val("R8", {16'h1234, 16'h00F0});

    // R7: block reset while strap drive active
    @(negedge clk); sys_rst_raw = 1'b1; #2;
    repeat (3) tick();
    check_val("R1", {16'hC30F, 16'hFFFF});
    @(negedge clk); rst = 1'b1; #2;
    tick(); check_val("R7", {16'h1234, 16'h00F0});
    @(negedge clk); rst = 1'b0; sys_rst_raw = 1'b0; #2;
    repeat (3) tick();

    // random mix
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 9) == 0) sys_rst_raw = ~sys_rst_raw;
      bus_busy  = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 19) == 0) mode_en = ~mode_en;
      if ($urandom_range(0, 49) == 0) strap_word = 16'($urandom);
      port_dout = 16'($urandom);
      port_oe   = 16'($urandom);
      #2;
      if (bus_busy)      check("R3");
      else if (!mode_en) check("R4");
      else if (exp_take()) check("R1");
      else               check("R8");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule